// File: doc/BRIEF.md
# Switch-on-Event Thread Context Controller

This block steers a single-issue pipeline between several hardware thread contexts, keeping one program counter per context and choosing which of them feeds fetch. The active context runs until something makes continuing pointless or unfair. That can be a cache miss, a remote (network) memory access, a synchronization fault, an explicit yield hint from the thread, or the expiry of its issue quantum. When one of these happens, the controller drains the pipeline with a one-cycle flush pulse and then redirects fetch to the next context that can make progress.

A context that leaves because it is waiting on memory is parked as blocked. It only becomes eligible again when the memory system reports that its data has come back. If every context is blocked, fetch is held off and the current selection is kept until a return revives one of them. Contexts that yield for other reasons stay eligible, but they are only taken back when nobody else is ready.

Top module: `ctx_switch_ctrl`

## Requirements
- R1: While reset is asserted, activeCtx is 0, readyMask is all ones, and flush and fetchValid are 0. fetchValid rises after the first clock edge with reset released, with fetchPc equal to BOOT_BASE.
- R2: Context i boots at PC BOOT_BASE + i*BOOT_STRIDE. Each cycle the active context issues (issueValid with fetchValid high), its PC advances by INSTR_BYTES. A context's PC is kept unchanged while other contexts run.
- R3: evMiss or evNet while fetchValid is 1 triggers a switch and clears the outgoing context's bit in readyMask (1 = ready) on the same edge as the flush.
- R4: evSync or evHint while fetchValid is 1 triggers a switch, and the outgoing context stays ready.
- R5: A switch drives flush high for exactly one cycle with fetchValid low in that cycle. The new context's PC is presented with fetchValid high in the following cycle.
- R6: The next context is the first ready one in increasing index order, wrapping, starting at activeCtx+1. The outgoing context is picked again only if it is the sole ready context.
- R7: If no context is ready after a switch, fetchValid stays low and activeCtx is held. When a return makes a context ready, that context becomes active with fetchValid high one edge later, and no second flush is issued.
- R8: retValid with context index retCtx sets that context ready. A return takes effect before a switch decision made in the same cycle, so the returned context can be chosen in that switch.
- R9: The quantum counter loads `quantum` at start and on every switch. It decrements only on cycles where the active context issues. The issue that exhausts it forces a switch, and a quantum of 0 acts as 1.
- R10: Switch events presented while fetchValid is 0 (during a flush cycle or a stall) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| quantum | input | QUANT_W | Issue cycles allowed per turn |
| issueValid | input | 1 | Active context issued an instruction this cycle |
| evMiss | input | 1 | Cache miss on active context (blocking) |
| evNet | input | 1 | Remote memory access on active context (blocking) |
| evSync | input | 1 | Synchronization fault on active context |
| evHint | input | 1 | Explicit yield hint from active context |
| retValid | input | 1 | Memory data returned for context retCtx |
| retCtx | input | CTX_W | Context index of the data return |
| flush | output | 1 | One-cycle pipeline flush pulse |
| fetchValid | output | 1 | fetchPc is valid for fetch |
| fetchPc | output | PC_W | PC of the active context |
| activeCtx | output | CTX_W | Currently selected context |
| readyMask | output | NUM_CTX | Per-context ready flag (1 = ready) |

## Verification
A corrupted ready flag shows on readyMask on the very next edge. It also steers the next switch to the wrong context, so activeCtx differs from the expected round-robin pick one cycle after the flush. A lost quantum count or a stuck state register shows up as a missing, early or repeated flush pulse, or as fetchValid staying low. A damaged PC register is exposed as soon as its context is selected again.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

  typedef enum logic [1:0] {
    ST_LAUNCH = 2'd0,
    ST_RUN    = 2'd1,
    ST_FLUSH  = 2'd2,
    ST_STALL  = 2'd3
  } ctxState_e;

  // Strobes from control to the PC datapath
  typedef struct packed {
    logic pcStep;   // active context issued, advance its PC
    logic fetchEn;  // fetch output is valid
  } dpStrobe_t;

endpackage

// File: rtl/ctxsw_datapath.sv
module ctxsw_datapath #(
  parameter int NUM_CTX = 4,
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] BOOT_BASE = 32'h0000_1000,
  parameter logic [PC_W-1:0] BOOT_STRIDE = 32'h0000_0100,
  parameter int INSTR_BYTES = 4,
  localparam int CTX_W = $clog2(NUM_CTX)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctxsw_pkg::dpStrobe_t  strobe,
  input  logic [CTX_W-1:0]      activeCtx,
  output logic                  fetchValid,
  output logic [PC_W-1:0]       fetchPc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  logic [PC_W-1:0] pcFile [NUM_CTX];

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_pc
    localparam logic [PC_W-1:0] BOOT_PC = BOOT_BASE + PC_W'(g) * BOOT_STRIDE;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pcFile[g] <= BOOT_PC;
      end else if (strobe.pcStep && (activeCtx == CTX_W'(g))) begin
        pcFile[g] <= pcFile[g] + STEP;
      end
    end
  end

  assign fetchPc    = pcFile[activeCtx];
  assign fetchValid = strobe.fetchEn;

endmodule

// File: rtl/ctxsw_ctrl.sv
module ctxsw_ctrl #(
  parameter int NUM_CTX = 4,
  parameter int QUANT_W = 16,
  localparam int CTX_W = $clog2(NUM_CTX)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [QUANT_W-1:0]    quantum,
  input  logic                  issueValid,
  input  logic                  evMiss,
  input  logic                  evNet,
  input  logic                  evSync,
  input  logic                  evHint,
  input  logic                  retValid,
  input  logic [CTX_W-1:0]      retCtx,
  output logic                  flush,
  output logic [CTX_W-1:0]      activeCtx,
  output logic [NUM_CTX-1:0]    readyMask,
  output ctxsw_pkg::dpStrobe_t  strobe
);
  import ctxsw_pkg::*;

  ctxState_e          state;
  logic [CTX_W-1:0]   activeQ;
  logic [NUM_CTX-1:0] readyQ;
  logic               flushQ;
  logic               fetchQ;
  logic [QUANT_W-1:0] quantCnt;

  logic               inRun;
  logic               timeout;
  logic               swReq;
  logic               blockNow;
  logic [NUM_CTX-1:0] retMask;
  logic [NUM_CTX-1:0] readyNext;
  logic               pickFound;
  logic [CTX_W-1:0]   pickCtx;
  logic [CTX_W-1:0]   probe;

  // Event decode; data return is folded in before the pick
  always_comb begin
    inRun    = (state == ST_RUN);
    timeout  = inRun && issueValid && (quantCnt <= QUANT_W'(1));
    swReq    = inRun && (evMiss || evNet || evSync || evHint || timeout);
    blockNow = inRun && (evMiss || evNet);

    retMask = '0;
    if (retValid) retMask[retCtx] = 1'b1;

    readyNext = readyQ | retMask;
    if (blockNow) readyNext[activeQ] = 1'b0;
  end

  // Round-robin pick: nearest ready context after the current one,
  // the current one itself being the last candidate
  always_comb begin
    pickFound = 1'b0;
    pickCtx   = activeQ;
    probe     = '0;
    for (int i = NUM_CTX; i >= 1; i--) begin
      probe = CTX_W'((int'(activeQ) + i) % NUM_CTX);
      if (readyNext[probe]) begin
        pickFound = 1'b1;
        pickCtx   = probe;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_LAUNCH;
      activeQ  <= '0;
      readyQ   <= '1;
      flushQ   <= 1'b0;
      fetchQ   <= 1'b0;
      quantCnt <= '0;
    end else begin
      readyQ <= readyNext;
      flushQ <= 1'b0;
      case (state)
        ST_LAUNCH: begin
          state    <= ST_RUN;
          fetchQ   <= 1'b1;
          quantCnt <= quantum;
        end
        ST_RUN: begin
          if (swReq) begin
            flushQ   <= 1'b1;
            fetchQ   <= 1'b0;
            quantCnt <= quantum;
            if (pickFound) begin
              activeQ <= pickCtx;
              state   <= ST_FLUSH;
            end else begin
              state <= ST_STALL;
            end
          end else if (issueValid) begin
            quantCnt <= quantCnt - QUANT_W'(1);
          end
        end
        ST_FLUSH: begin
          state  <= ST_RUN;
          fetchQ <= 1'b1;
        end
        ST_STALL: begin
          if (pickFound) begin
            activeQ  <= pickCtx;
            state    <= ST_RUN;
            fetchQ   <= 1'b1;
            quantCnt <= quantum;
          end
        end
        default: state <= ST_LAUNCH;
      endcase
    end
  end

  assign flush          = flushQ;
  assign activeCtx      = activeQ;
  assign readyMask      = readyQ;
  assign strobe.pcStep  = inRun && issueValid;
  assign strobe.fetchEn = fetchQ;

endmodule

// File: rtl/ctx_switch_ctrl.sv
module ctx_switch_ctrl #(
  parameter int NUM_CTX = 4,
  parameter int PC_W = 32,
  parameter int QUANT_W = 16,
  parameter logic [PC_W-1:0] BOOT_BASE = 32'h0000_1000,
  parameter logic [PC_W-1:0] BOOT_STRIDE = 32'h0000_0100,
  parameter int INSTR_BYTES = 4,
  localparam int CTX_W = $clog2(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [QUANT_W-1:0] quantum,
  input  logic               issueValid,
  input  logic               evMiss,
  input  logic               evNet,
  input  logic               evSync,
  input  logic               evHint,
  input  logic               retValid,
  input  logic [CTX_W-1:0]   retCtx,
  output logic               flush,
  output logic               fetchValid,
  output logic [PC_W-1:0]    fetchPc,
  output logic [CTX_W-1:0]   activeCtx,
  output logic [NUM_CTX-1:0] readyMask
);

  ctxsw_pkg::dpStrobe_t strobe;

  ctxsw_ctrl #(
    .NUM_CTX (NUM_CTX),
    .QUANT_W (QUANT_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .quantum    (quantum),
    .issueValid (issueValid),
    .evMiss     (evMiss),
    .evNet      (evNet),
    .evSync     (evSync),
    .evHint     (evHint),
    .retValid   (retValid),
    .retCtx     (retCtx),
    .flush      (flush),
    .activeCtx  (activeCtx),
    .readyMask  (readyMask),
    .strobe     (strobe)
  );

  ctxsw_datapath #(
    .NUM_CTX     (NUM_CTX),
    .PC_W        (PC_W),
    .BOOT_BASE   (BOOT_BASE),
    .BOOT_STRIDE (BOOT_STRIDE),
    .INSTR_BYTES (INSTR_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .activeCtx  (activeCtx),
    .fetchValid (fetchValid),
    .fetchPc    (fetchPc)
  );

endmodule

// File: rtl/ctxsw_checker.sv
module ctxsw_checker #(
  parameter int NUM_CTX = 4,
  localparam int CTX_W = $clog2(NUM_CTX)
) (
  input logic               clk,
  input logic               rstN,
  input logic               evMiss,
  input logic               evNet,
  input logic               evSync,
  input logic               evHint,
  input logic               retValid,
  input logic [CTX_W-1:0]   retCtx,
  input logic               flush,
  input logic               fetchValid,
  input logic [CTX_W-1:0]   activeCtx,
  input logic [NUM_CTX-1:0] readyMask
);

  p_flush_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !flush);

  p_flush_nofetch_r5: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !fetchValid);

  p_block_on_miss_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && (evMiss || evNet)) |=> (flush && !readyMask[$past(activeCtx)]));

  p_soft_switch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !evMiss && !evNet && (evSync || evHint))
      |=> (flush && readyMask[$past(activeCtx)]));

  p_active_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> readyMask[activeCtx]);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchValid && !retValid) |=> $stable(activeCtx));

  p_return_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && !(fetchValid && (evMiss || evNet) && (retCtx == activeCtx)))
      |=> readyMask[$past(retCtx)]);

  p_idle_no_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> !flush);

endmodule

bind ctx_switch_ctrl ctxsw_checker #(.NUM_CTX(NUM_CTX)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .evMiss     (evMiss),
  .evNet      (evNet),
  .evSync     (evSync),
  .evHint     (evHint),
  .retValid   (retValid),
  .retCtx     (retCtx),
  .flush      (flush),
  .fetchValid (fetchValid),
  .activeCtx  (activeCtx),
  .readyMask  (readyMask)
);

// File: tb/test_ctx_switch_ctrl.sv
`timescale 1ns/1ps
module test_ctx_switch_ctrl;

  localparam int NUM_CTX = 4;
  localparam int PC_W = 32;
  localparam int QUANT_W = 16;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] STRIDE = 32'h0000_0100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [QUANT_W-1:0] quantum = 16'd1000;
  logic issueValid = 1'b0, evMiss = 1'b0, evNet = 1'b0, evSync = 1'b0, evHint = 1'b0;
  logic retValid = 1'b0;
  logic [1:0] retCtx = 2'd0;
  logic flush, fetchValid;
  logic [PC_W-1:0] fetchPc;
  logic [1:0] activeCtx;
  logic [3:0] readyMask;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  ctx_switch_ctrl #(
    .NUM_CTX(NUM_CTX), .PC_W(PC_W), .QUANT_W(QUANT_W),
    .BOOT_BASE(BASE), .BOOT_STRIDE(STRIDE), .INSTR_BYTES(4)
  ) i_ctx_switch_ctrl (
    .clk(clk), .rstN(rstN), .quantum(quantum), .issueValid(issueValid),
    .evMiss(evMiss), .evNet(evNet), .evSync(evSync), .evHint(evHint),
    .retValid(retValid), .retCtx(retCtx), .flush(flush), .fetchValid(fetchValid),
    .fetchPc(fetchPc), .activeCtx(activeCtx), .readyMask(readyMask)
  );

  // Row: [15]miss [14]net [13]sync [12]hint [11]issue [10]retV [9:8]retCtx |
  //      expected after edge: [7]flush [6]fetchValid [5:4]activeCtx [3:0]readyMask
  localparam logic [15:0] VEC [23] = '{
    16'b0000_0000_0100_1111, // idle
    16'b1000_0000_1001_1110, // R3 miss ctx0 -> ctx1, ctx0 blocked
    16'b0001_0000_0101_1110, // R10 hint in flush cycle ignored
    16'b0001_0000_1010_1110, // R4 hint ctx1 -> ctx2, stays ready
    16'b0000_0000_0110_1110, // R5 fetch back
    16'b0100_0000_1011_1010, // R3 net access ctx2 blocked -> ctx3
    16'b0000_0000_0111_1010,
    16'b0010_0000_1001_1010, // R6 sync ctx3 -> skip blocked ctx0 -> ctx1
    16'b0000_0000_0101_1010,
    16'b1000_0110_1010_1100, // R8 miss ctx1 + return ctx2 same cycle -> ctx2
    16'b0000_0000_0110_1100,
    16'b1000_0000_1011_1000, // miss ctx2 -> ctx3
    16'b0000_0000_0111_1000,
    16'b1000_0000_1011_0000, // R7 miss ctx3, none ready -> stall
    16'b0000_0000_0011_0000, // R7 held
    16'b0001_0000_0011_0000, // R10 hint while stalled ignored
    16'b0000_0101_0101_0010, // R7 return ctx1 resumes, no flush
    16'b0001_0000_1001_0010, // R6 sole ready picks itself
    16'b0000_0000_0101_0010,
    16'b0000_0101_0101_0010, // R8 return to ready ctx, no change
    16'b0000_0100_0101_0011, // R8 return ctx0
    16'b0010_0000_1000_0011, // R6 wrap from ctx1 to ctx0
    16'b0000_0000_0100_0011
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    {evMiss, evNet, evSync, evHint, issueValid, retValid, retCtx} = v;
    @(posedge clk); #1;
    {evMiss, evNet, evSync, evHint, issueValid, retValid, retCtx} = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
  endtask

  localparam logic [7:0] IDLE = 8'b0000_0000;
  localparam logic [7:0] ISS  = 8'b0000_1000;
  localparam logic [7:0] HINT = 8'b0001_0000;
  localparam logic [7:0] SYNC = 8'b0010_0000;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    // R1 reset values
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset act/fv/flush/ready", {25'd0, activeCtx, fetchValid, flush, readyMask},
        {25'd0, 2'd0, 1'b0, 1'b0, 4'b1111});
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 fetch valid after reset", {31'd0, fetchValid}, 32'd1);
    chk("R1 R2 boot pc ctx0", fetchPc, BASE);

    // Table walk: R3 R4 R5 R6 R7 R8 R10
    for (int k = 0; k < 23; k++) begin
      drive(VEC[k][15:8]);
      chk($sformatf("R3-R10 table row %0d", k),
          {24'd0, flush, fetchValid, activeCtx, readyMask}, {24'd0, VEC[k][7:0]});
    end

    // R2 per-context PC tracking, R5 flush timing
    doReset();
    repeat (3) drive(ISS);
    chk("R2 pc advance ctx0", fetchPc, BASE + 32'd12);
    drive(HINT);
    chk("R5 flush pulse, fetch low", {30'd0, flush, fetchValid}, {30'd0, 2'b10});
    drive(IDLE);
    chk("R5 flush dropped, fetch valid", {30'd0, flush, fetchValid}, {30'd0, 2'b01});
    chk("R2 ctx1 boot pc", fetchPc, BASE + STRIDE);
    drive(ISS);
    chk("R2 ctx1 pc advance", fetchPc, BASE + STRIDE + 32'd4);
    drive(SYNC); drive(IDLE);
    chk("R2 ctx2 boot pc", fetchPc, BASE + 2 * STRIDE);
    drive(SYNC); drive(IDLE);
    drive(SYNC); drive(IDLE);
    chk("R2 ctx0 pc kept across switches", {activeCtx, fetchPc[29:0]}, {2'd0, BASE[29:0] + 30'd12});

    // R9 quantum timeout, counting only issue cycles
    quantum = 16'd3;
    doReset();
    drive(ISS); drive(IDLE); drive(ISS); drive(IDLE);
    chk("R9 no early timeout", {30'd0, flush, fetchValid}, {30'd0, 2'b01});
    drive(ISS);
    chk("R9 timeout on 3rd issue", {29'd0, flush, activeCtx}, {29'd0, 1'b1, 2'd1});
    drive(IDLE);
    drive(ISS); drive(ISS);
    chk("R9 quantum reloaded after switch", {30'd0, flush, fetchValid}, {30'd0, 2'b01});
    drive(ISS);
    chk("R9 timeout for ctx1", {29'd0, flush, activeCtx}, {29'd0, 1'b1, 2'd2});

    quantum = 16'd0;
    doReset();
    drive(ISS);
    chk("R9 quantum zero acts as one", {29'd0, flush, activeCtx}, {29'd0, 1'b1, 2'd1});

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule